// File: doc/BRIEF.md
# Monotonic Dual-Rail Half Adder

This block is a purely combinational half adder for circuits in which every logical bit travels on two wires, a true rail and a false rail. It uses only positive gates, AND and OR, so no output rail can fall while its inputs rise. Inversion needs no gate: the two rails of a bit are exchanged. The block has no clock and no state. An outside controller alternates between a precharge phase, in which all rails are driven low, and an evaluation phase, in which each input pair settles to a valid code. The block only maps rail pairs to rail pairs.

Each of `LANES` independent lanes splits its two operands into copies and exchanges the two middle copies. It then feeds one operand pair to a dual-rail AND, which gives the carry, and the other pair to a dual-rail XOR, which gives the sum. The package also provides the rail-level AND, OR, NOT, XOR and fork functions for reuse elsewhere. The carry can resolve early: a false operand forces a false carry even while the other operand is still null.

Top module: `dr_half_adder`

## Requirements
- R1: Each bit is a rail pair {true, false}: 00 means null, 10 means logic 1, 01 means logic 0, and 11 is a fault code.
- R2: When both operands of a lane are null, the carry and the sum of that lane are both null.
- R3: When both operands are valid, the carry encodes the AND of the two operand values.
- R4: When both operands are valid, the sum encodes the XOR of the two operand values.
- R5: When one operand is logic 0 and the other is null, the carry is already logic 0 (early evaluation).
- R6: When either operand is null, the sum is null.
- R7: When one operand is logic 1 and the other is null, the carry stays null.
- R8: No output pair shows the fault code while both operands of its lane are free of faults.
- R9: Each lane depends only on its own operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a_t | input | LANES | true rail of operand A, one bit per lane |
| op_a_f | input | LANES | false rail of operand A |
| op_b_t | input | LANES | true rail of operand B |
| op_b_f | input | LANES | false rail of operand B |
| carry_t | output | LANES | true rail of the carry |
| carry_f | output | LANES | false rail of the carry |
| sum_t | output | LANES | true rail of the sum |
| sum_f | output | LANES | false rail of the sum |

## Verification
The embedded checks watch every input change for four properties: null propagation through both cells, the early false carry, a sum held null while an operand is null, and the absence of the fault code on error-free inputs. The correct arithmetic values for all four valid operand combinations, a carry that stays null beside a lone logic 1, and the independence of lanes under mixed per-lane codes can only be shown by the bench. It checks them against its own three-valued model over directed and seeded random patterns.

// File: rtl/dr_pkg.sv
package dr_pkg;

    // rail pair: bit 1 = true rail, bit 0 = false rail (R1)
    typedef logic [1:0] rail_t;

    localparam rail_t RAIL_NULL  = 2'b00;
    localparam rail_t RAIL_ONE   = 2'b10;
    localparam rail_t RAIL_ZERO  = 2'b01;
    localparam rail_t RAIL_FAULT = 2'b11;

    typedef struct packed {
        rail_t first;
        rail_t second;
    } rail_fork_t;

    function automatic rail_t rail_and(rail_t a, rail_t b);
        return {a[1] & b[1], a[0] | b[0]};
    endfunction

    function automatic rail_t rail_or(rail_t a, rail_t b);
        return {a[1] | b[1], a[0] & b[0]};
    endfunction

    // inversion is a rail exchange, no gate
    function automatic rail_t rail_not(rail_t a);
        return {a[0], a[1]};
    endfunction

    function automatic rail_t rail_xor(rail_t a, rail_t b);
        return {(a[1] & b[0]) | (a[0] & b[1]),
                (a[1] & b[1]) | (a[0] & b[0])};
    endfunction

    function automatic rail_fork_t rail_fork(rail_t a);
        rail_fork_t r;
        r.first  = a;
        r.second = a;
        return r;
    endfunction

    function automatic logic rail_is_null(rail_t a);
        return a == RAIL_NULL;
    endfunction

    function automatic logic rail_is_valid(rail_t a);
        return a[1] ^ a[0];
    endfunction

endpackage

// File: rtl/dr_and_cell.sv
module dr_and_cell
    import dr_pkg::*;
(
    input  rail_t in_x,
    input  rail_t in_y,
    output rail_t out_z
);

    always_comb begin
        out_z = rail_and(in_x, in_y);
    end

    always_comb begin
        // R2
        and_null_chk: assert (!(rail_is_null(in_x) && rail_is_null(in_y)) || rail_is_null(out_z))
            else $error("and cell: null inputs gave %b", out_z);
        // R5
        and_early_zero_chk: assert (!((in_x == RAIL_ZERO && in_y == RAIL_NULL) ||
                                      (in_y == RAIL_ZERO && in_x == RAIL_NULL)) || out_z == RAIL_ZERO)
            else $error("and cell: early zero missing, got %b", out_z);
    end

endmodule

// File: rtl/dr_xor_cell.sv
module dr_xor_cell
    import dr_pkg::*;
(
    input  rail_t in_x,
    input  rail_t in_y,
    output rail_t out_z
);

    always_comb begin
        out_z = rail_xor(in_x, in_y);
    end

    always_comb begin
        // R6
        xor_null_hold_chk: assert (!((rail_is_null(in_x) && in_y != RAIL_FAULT) ||
                                     (rail_is_null(in_y) && in_x != RAIL_FAULT)) || rail_is_null(out_z))
            else $error("xor cell: output %b with a null operand", out_z);
    end

endmodule

// File: rtl/dr_half_adder.sv
module dr_half_adder
    import dr_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic [LANES-1:0] op_a_t,
    input  logic [LANES-1:0] op_a_f,
    input  logic [LANES-1:0] op_b_t,
    input  logic [LANES-1:0] op_b_f,
    output logic [LANES-1:0] carry_t,
    output logic [LANES-1:0] carry_f,
    output logic [LANES-1:0] sum_t,
    output logic [LANES-1:0] sum_f
);

    localparam int WIRES = 4;

    for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
        rail_t      a_r, b_r;
        rail_fork_t a_fk, b_fk;
        rail_t      spread [WIRES];
        rail_t      crossed[WIRES];
        rail_t      carry_r, sum_r;

        always_comb begin
            a_r  = {op_a_t[ln], op_a_f[ln]};
            b_r  = {op_b_t[ln], op_b_f[ln]};
            a_fk = rail_fork(a_r);
            b_fk = rail_fork(b_r);
            spread[0] = a_fk.first;
            spread[1] = a_fk.second;
            spread[2] = b_fk.first;
            spread[3] = b_fk.second;
            // exchange the two middle pairs, both rails together
            crossed[0] = spread[0];
            crossed[1] = spread[2];
            crossed[2] = spread[1];
            crossed[3] = spread[3];
        end

        dr_and_cell u_carry (
            .in_x (crossed[0]),
            .in_y (crossed[1]),
            .out_z(carry_r)
        );

        dr_xor_cell u_sum (
            .in_x (crossed[2]),
            .in_y (crossed[3]),
            .out_z(sum_r)
        );

        always_comb begin
            carry_t[ln] = carry_r[1];
            carry_f[ln] = carry_r[0];
            sum_t[ln]   = sum_r[1];
            sum_f[ln]   = sum_r[0];
        end

        always_comb begin
            // R8
            no_fault_out_chk: assert (a_r == RAIL_FAULT || b_r == RAIL_FAULT ||
                                      (carry_r != RAIL_FAULT && sum_r != RAIL_FAULT))
                else $error("lane %0d: fault code on output", ln);
        end
    end

endmodule

// File: tb/tb_dr_half_adder.sv
module tb_dr_half_adder;

    localparam int LANES = 4;
    // bench codes: 0 null, 1 logic one, 2 logic zero (R1)
    localparam int C_N = 0;
    localparam int C_T = 1;
    localparam int C_F = 2;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic [LANES-1:0] a_t, a_f, b_t, b_f;
    logic [LANES-1:0] c_t, c_f, s_t, s_f;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    dr_half_adder #(.LANES(LANES)) dut (
        .op_a_t (a_t), .op_a_f (a_f),
        .op_b_t (b_t), .op_b_f (b_f),
        .carry_t(c_t), .carry_f(c_f),
        .sum_t  (s_t), .sum_f  (s_f)
    );

    function automatic logic [1:0] enc(int code);
        case (code)
            C_T:     return 2'b10;
            C_F:     return 2'b01;
            default: return 2'b00;
        endcase
    endfunction

    function automatic int exp_carry(int a, int b);
        if (a == C_T && b == C_T) return C_T;
        if (a == C_F || b == C_F) return C_F;
        return C_N;
    endfunction

    function automatic int exp_sum(int a, int b);
        if (a == C_N || b == C_N) return C_N;
        return (a != b) ? C_T : C_F;
    endfunction

    task automatic check(string req, int ln, logic [1:0] act, logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s lane %0d: actual %b expected %b", req, ln, act, exp);
        end
    endtask

    task automatic apply(int ac[LANES], int bc[LANES]);
        @(negedge clk);
        for (int i = 0; i < LANES; i++) begin
            {a_t[i], a_f[i]} = enc(ac[i]);
            {b_t[i], b_f[i]} = enc(bc[i]);
        end
        #1;
        for (int i = 0; i < LANES; i++) begin
            string rc, rs;
            logic [1:0] cv, sv;
            cv = {c_t[i], c_f[i]};
            sv = {s_t[i], s_f[i]};
            if (ac[i] != C_N && bc[i] != C_N) begin
                rc = "R1/R3/R9"; rs = "R1/R4/R9";
            end else if (ac[i] == C_N && bc[i] == C_N) begin
                rc = "R2"; rs = "R2";
            end else begin
                rc = (ac[i] == C_F || bc[i] == C_F) ? "R5" : "R7";
                rs = "R6";
            end
            check(rc, i, cv, enc(exp_carry(ac[i], bc[i])));
            check(rs, i, sv, enc(exp_sum(ac[i], bc[i])));
            checks++;
            if (cv == 2'b11 || sv == 2'b11) begin
                errors++;
                $display("FAIL R8 lane %0d: actual carry %b sum %b expected no 11", i, cv, sv);
            end
        end
    endtask

    initial begin
        #400000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int ac[LANES], bc[LANES];
        int seed_dummy;
        a_t = '0; a_f = '0; b_t = '0; b_f = '0;
        seed_dummy = $urandom(32'h5eed_0042);
        // precharge state: all null (R2)
        for (int i = 0; i < LANES; i++) begin ac[i] = C_N; bc[i] = C_N; end
        apply(ac, bc);
        // all four valid combinations across lanes (R3, R4)
        ac = '{C_F, C_F, C_T, C_T};
        bc = '{C_F, C_T, C_F, C_T};
        apply(ac, bc);
        // back to null after evaluation (R2)
        ac = '{C_N, C_N, C_N, C_N};
        bc = '{C_N, C_N, C_N, C_N};
        apply(ac, bc);
        // partially null: early zero (R5) and held null (R6, R7)
        ac = '{C_F, C_N, C_T, C_N};
        bc = '{C_N, C_F, C_N, C_T};
        apply(ac, bc);
        // mixed lanes: one lane valid beside null neighbours (R9)
        ac = '{C_T, C_N, C_F, C_N};
        bc = '{C_T, C_N, C_T, C_N};
        apply(ac, bc);
        // seeded random error-free codes
        for (int n = 0; n < 300; n++) begin
            for (int i = 0; i < LANES; i++) begin
                ac[i] = int'($urandom_range(2, 0));
                bc[i] = int'($urandom_range(2, 0));
            end
            apply(ac, bc);
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule